// File: doc/BRIEF.md
# Round-Robin Phase Line Sequencer

This block drives a bank of output lines so that they take turns being active. Exactly one line is high at a time, and the active line moves one position forward on every clock edge where the step strobe is high. After the last line it returns to line 0. The block suits drivers that must fire a row of switches in strict rotation. A glitch on a line that is not selected would switch the wrong device, so the design is built to prevent it.

The position is held in a twisted ring of PHASES/2 flops. The ring shifts left, and the inverted top bit feeds the bottom bit. It first fills with ones from bit 0 upward and then empties to zeros, so each advance flips a single flop. Each line is decoded from one pair of adjacent ring bits by a two-input gate with one input inverted, and then registered. The lines therefore never see the false in-between codes that a binary count can pass through. A guard watches the ring for any pattern outside the legal rotation and clears the ring on the next edge, so the sequence cannot settle into a bad loop.

Top module: `rr_phase_seq`

## Requirements
- R1: A clock edge with `rst` high leaves `phase_o` equal to 1 (only line 0 active) and `wrap_o` low, whatever `step_en` is.
- R2: At every clock edge after reset, exactly one bit of `phase_o` is high.
- R3: On an edge with `step_en` high and a legal ring, the active line moves from index i to index (i+1) mod PHASES. Lines follow ascending bit index, and the ring flips only one of its bits on that edge.
- R4: On an edge with `step_en` low and a legal ring, `phase_o` keeps its value and `wrap_o` is low.
- R5: `wrap_o` is high for exactly the one cycle after an edge that moves the active line from index PHASES-1 to index 0. It is low at all other times.
- R6: When the ring holds an illegal pattern (more than one 0/1 boundary between adjacent bits), the next edge clears the ring to all zeros. After that edge `phase_o` equals 1 and `wrap_o` is low, even if `step_en` is high, and stepping then resumes from line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance strobe; sampled at each rising edge |
| phase_o | output | PHASES | Registered one-hot phase lines, bit i is line i |
| wrap_o | output | 1 | Registered one-cycle marker for the return to line 0 |

## Verification
The bench walks the rotation many times with the strobe held high and with irregular strobe patterns, so it can catch a design that skips or repeats a line at the fill/empty turnaround of the ring. The same walks would catch a wrap marker that fires on the wrong phase or stays high when the strobe is low at line 0. The bench loads every illegal ring pattern in turn, with the strobe both high and low, and expects line 0 on the next edge. A design with a weak legality test would keep two lines high or wander through a false loop. A reset applied in the middle of a run with the strobe high must still land on line 0.

// File: rtl/rr_phase_pkg.sv
`timescale 1ns/1ps
package rr_phase_pkg;

  // Next-state operation selected for the twisted ring
  typedef enum logic [1:0] {
    RING_HOLD  = 2'd0,
    RING_STEP  = 2'd1,
    RING_CLEAR = 2'd2
  } ring_op_e;

  // A twisted ring of W flops yields 2*W distinct positions
  function automatic int unsigned ring_width(input int unsigned phases);
    return phases / 2;
  endfunction

endpackage

// File: rtl/rr_ring_guard.sv
`timescale 1ns/1ps
module rr_ring_guard #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] state_i,
  output logic             legal_o
);

  // One flag per adjacent bit pair marks a 0/1 boundary
  logic [WIDTH-2:0] boundary_w;

  for (genvar g = 0; g < WIDTH - 1; g++) begin : g_bound
    assign boundary_w[g] = state_i[g] ^ state_i[g+1];
  end

  // Legal rotation patterns carry at most one boundary
  assign legal_o = $onehot0(boundary_w);

endmodule

// File: rtl/rr_ring_state.sv
`timescale 1ns/1ps
module rr_ring_state
  import rr_phase_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             legal_i,
  output logic [WIDTH-1:0] state_q,
  output logic [WIDTH-1:0] state_d,
  output logic             at_last_o
);

  // Position 2*WIDTH-1: only the top bit still set
  localparam logic [WIDTH-1:0] LAST_PAT = {1'b1, {(WIDTH-1){1'b0}}};

  ring_op_e op;

  always_comb begin
    if (!legal_i) begin
      op = RING_CLEAR;
    end else if (step_i) begin
      op = RING_STEP;
    end else begin
      op = RING_HOLD;
    end
  end

  always_comb begin
    case (op)
      RING_STEP:  state_d = {state_q[WIDTH-2:0], ~state_q[WIDTH-1]};
      RING_CLEAR: state_d = '0;
      default:    state_d = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
    end else begin
      state_q <= state_d;
    end
  end

  assign at_last_o = (state_q == LAST_PAT);

endmodule

// File: rtl/rr_phase_decode.sv
`timescale 1ns/1ps
module rr_phase_decode #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]   state_i,
  output logic [2*WIDTH-1:0] phase_o
);

  // Ends of the ring pick out the all-zero and all-one positions
  assign phase_o[0]     = ~state_i[WIDTH-1] & ~state_i[0];
  assign phase_o[WIDTH] =  state_i[WIDTH-1] &  state_i[0];

  // Filling half: boundary where ones stop; emptying half: where zeros stop
  for (genvar k = 1; k < WIDTH; k++) begin : g_pair
    assign phase_o[k]         =  state_i[k-1] & ~state_i[k];
    assign phase_o[WIDTH + k] = ~state_i[k-1] &  state_i[k];
  end

endmodule

// File: rtl/rr_phase_seq.sv
`timescale 1ns/1ps
module rr_phase_seq
  import rr_phase_pkg::*;
#(
  parameter int unsigned PHASES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  output logic [PHASES-1:0] phase_o,
  output logic              wrap_o
);

  localparam int unsigned RING_W = ring_width(PHASES);

  logic [RING_W-1:0] ring_q;
  logic [RING_W-1:0] ring_d;
  logic              ring_ok;
  logic              ring_last;
  logic [PHASES-1:0] phase_d;
  logic [PHASES-1:0] phase_q;
  logic              wrap_q;

  rr_ring_guard #(.WIDTH(RING_W)) u_guard (
    .state_i (ring_q),
    .legal_o (ring_ok)
  );

  rr_ring_state #(.WIDTH(RING_W)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .step_i    (step_en),
    .legal_i   (ring_ok),
    .state_q   (ring_q),
    .state_d   (ring_d),
    .at_last_o (ring_last)
  );

  // Decode the upcoming ring value so the registered lines track the ring
  rr_phase_decode #(.WIDTH(RING_W)) u_decode (
    .state_i (ring_d),
    .phase_o (phase_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PHASES'(1);
      wrap_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wrap_q  <= step_en & ring_ok & ring_last;
    end
  end

  assign phase_o = phase_q;
  assign wrap_o  = wrap_q;

endmodule

// File: rtl/rr_phase_seq_chk.sv
`timescale 1ns/1ps
module rr_phase_seq_chk #(
  parameter int unsigned PHASES = 16,
  parameter int unsigned RING_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              step_en,
  input logic [PHASES-1:0] phase_o,
  input logic              wrap_o,
  input logic [RING_W-1:0] ring_q,
  input logic              ring_ok
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  AST_RESET_PHASE0: assert property (@(posedge clk) (armed && $past(rst)) |-> (phase_o == PHASES'(1)) && !wrap_o); // R1

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst) $countones(phase_o) == 1); // R2

  AST_STEP_ROTATE: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(ring_ok) && $past(step_en)) |-> phase_o == {$past(phase_o[PHASES-2:0]), $past(phase_o[PHASES-1])}); // R3

  AST_RING_ONE_BIT: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(ring_ok) && ring_ok) |-> $countones(ring_q ^ $past(ring_q)) <= 1); // R3

  AST_HOLD_LINES: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(ring_ok) && !$past(step_en)) |-> $stable(phase_o) && !wrap_o); // R4

  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (rst) wrap_o |-> phase_o[0] && $past(phase_o[PHASES-1])); // R5

  AST_WRAP_ON_LAST: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(ring_ok) && $past(step_en) && $past(phase_o[PHASES-1])) |-> wrap_o); // R5

  AST_ILLEGAL_CLEARS: assert property (@(posedge clk) disable iff (rst) !ring_ok |=> (ring_q == '0) && (phase_o == PHASES'(1)) && !wrap_o); // R6

endmodule

bind rr_phase_seq rr_phase_seq_chk #(.PHASES(PHASES), .RING_W(RING_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .step_en (step_en),
  .phase_o (phase_o),
  .wrap_o  (wrap_o),
  .ring_q  (ring_q),
  .ring_ok (ring_ok)
);

// File: tb/rr_phase_seq_bench.sv
`timescale 1ns/1ps
module rr_phase_seq_bench;

  localparam int unsigned P      = 16;
  localparam int unsigned W      = P / 2;
  localparam real         CLK_NS = 4.0;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         step_en = 1'b0;
  logic [P-1:0] phase_o;
  logic         wrap_o;
  logic [W-1:0] pat;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_idx = 0;
  bit exp_wrap = 1'b0;

  always #(CLK_NS / 2.0) clk = ~clk;

  rr_phase_seq #(.PHASES(P)) u_rr_phase_seq (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .phase_o (phase_o),
    .wrap_o  (wrap_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic check_lines(input string req);
    logic [P-1:0] want;
    want = P'(1) << exp_idx;
    check(phase_o == want, req, 32'(phase_o), 32'(want));
    check($countones(phase_o) == 1, "R2 one-hot", 32'($countones(phase_o)), 32'd1);
    check(wrap_o == exp_wrap, "R5 wrap", 32'(wrap_o), 32'(exp_wrap));
  endtask

  // Drive at the falling edge, sample at the next falling edge
  task automatic tick(input bit st);
    step_en = st;
    @(posedge clk);
    @(negedge clk);
    if (st) begin
      exp_wrap = (exp_idx == P - 1);
      exp_idx  = (exp_idx + 1) % P;
    end else begin
      exp_wrap = 1'b0;
    end
    check_lines(st ? "R3 step" : "R4 hold");
  endtask

  // Legal ring patterns: low-order ones fill, or high-order ones remain
  function automatic bit ring_legal(input logic [W-1:0] v);
    for (int k = 0; k <= W; k++) begin
      if (v == W'((1 << k) - 1)) return 1'b1;
    end
    for (int j = 1; j < W; j++) begin
      if (v == W'(((1 << W) - 1) << j)) return 1'b1;
    end
    return 1'b0;
  endfunction

  initial begin
    #(CLK_NS * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_idx = 0; exp_wrap = 1'b0;
    check_lines("R1 reset");

    // Three full rotations with the strobe held high
    for (int i = 0; i < 3 * P; i++) tick(1'b1);

    // Strobe low holds the line
    for (int i = 0; i < 5; i++) tick(1'b0);

    // Irregular strobe pattern, including hold on line P-1 and line 0
    for (int i = 0; i < 6 * P; i++) tick(((i * 7) % 5) != 0);
    while (exp_idx != P - 1) tick(1'b1);
    tick(1'b0);
    tick(1'b1);
    tick(1'b0);

    // Every illegal ring pattern must clear to line 0 (R6)
    for (int p = 0; p < (1 << W); p++) begin
      if (ring_legal(W'(p))) continue;
      for (int s = 0; s < (p % 5) + 1; s++) tick(1'b1);
      @(negedge clk);
      step_en = p[0];
      pat = W'(p);
      force u_rr_phase_seq.u_ring.state_q = pat;
      #1;
      release u_rr_phase_seq.u_ring.state_q;
      @(posedge clk);
      @(negedge clk);
      exp_idx = 0; exp_wrap = 1'b0;
      check_lines("R6 illegal clear");
      tick(1'b1);
    end

    // Reset in mid-run with the strobe high (R1)
    for (int i = 0; i < 5; i++) tick(1'b1);
    step_en = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    exp_idx = 0; exp_wrap = 1'b0;
    check_lines("R1 reset over step");
    rst = 1'b0;
    tick(1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule